// File: doc/BRIEF.md
# Paging Window Address Translator

This block sits between a CPU with a 16-bit address bus and a flash array of up to 128 KB. The flash is split into eight 16 KB pages. The CPU address space is cut into four 16 KB quarters, and each quarter is routed as follows:

- **Lowest quarter:** always goes to RAM and registers. That RAM overlays physical flash page 0.
- **Second and top quarters:** hard-wired to physical pages 1 and 3.
- **Third quarter (0x8000–0xBFFF):** a movable window. A small page register picks which of the eight physical pages appears there.

Software reaches any page by writing the page register through a simple register-bus port and then accessing the window. The translation from CPU address to physical address and selects is purely combinational, using the CPU address and the current page register value. The page register resets to 2. With that value the window shows page 2, so CPU addresses 0x4000–0xFFFF read as one unbroken run across pages 1, 2 and 3.

Top module: `page_window_xlate`

## Requirements
- R1: After reset the page register holds 2, and `reg_rdata` reads 8'h02.
- R2: `reg_rdata` carries the page number in bits 2:0 and zero in bits 7:3. Bits 7:3 of a written value are discarded, so writing 8'hFD gives page 5.
- R3: A write to the page register changes the translation from the next clock edge onward. The cycle that carries the write still translates with the old page value.
- R4: For CPU addresses 0x8000–0xBFFF, `flash_sel` is 1 and `phys_addr` equals page × 0x4000 + (address − 0x8000).
- R5: For CPU addresses 0x4000–0x7FFF, `flash_sel` is 1 and `phys_addr` equals 0x4000 + (address − 0x4000), whatever the page register holds.
- R6: For CPU addresses 0xC000–0xFFFF, `flash_sel` is 1 and `phys_addr` equals 0xC000 + (address − 0xC000), whatever the page register holds.
- R7: For CPU addresses 0x0000–0x3FFF, `ram_sel` is 1 and `flash_sel` is 0. `phys_addr` equals the CPU address zero-extended, which is the shadowed spot in page 0.
- R8: For every CPU address exactly one of `flash_sel` and `ram_sel` is 1.
- R9: With page 0 the window reaches physical 0x00000–0x03FFF. With page 7 it reaches 0x1C000–0x1FFFF, and window address 0xBFFF gives 0x1FFFF.
- R10: A cycle with `reg_sel` low or `reg_wr` low leaves the page register unchanged, whatever `reg_wdata` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register-bus select for the page register |
| reg_wr | input | 1 | Register-bus write strobe |
| reg_wdata | input | 8 | Register-bus write data |
| reg_rdata | output | 8 | Page register read value |
| cpu_addr | input | 16 | CPU address to translate |
| phys_addr | output | 17 | Translated physical address |
| flash_sel | output | 1 | Access goes to flash |
| ram_sel | output | 1 | Access goes to RAM and registers |

## Verification
The hardest case to reach from the ports is a window access made in the very cycle that rewrites the page register. That access must still use the old page, while the following cycle uses the new one. The bench drives a page write together with a window address and checks the output before and after the edge. It then runs a long random stream that mixes writes, writes without select, and addresses near every quarter boundary. Each cycle is compared against a behavioural model, so page 0, page 7 and the 0x3FFF/0x4000 and 0xBFFF/0xC000 edges are all met under changing page values.

// File: rtl/pwx_pkg.sv
package pwx_pkg;
   typedef enum logic [1:0] {
      PWX_RAM   = 2'd0,
      PWX_FIXED = 2'd1,
      PWX_WIN   = 2'd2
   } pwx_region_e;
endpackage

// File: rtl/pwx_page_reg.sv
module pwx_page_reg #(
   parameter int REG_DW     = 8,
   parameter int PAGE_BITS  = 3,
   parameter int RESET_PAGE = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_DW-1:0]    wdata,
   output logic [PAGE_BITS-1:0] page_q,
   output logic [REG_DW-1:0]    rdata
);
   localparam logic [PAGE_BITS-1:0] RST_VAL = PAGE_BITS'(RESET_PAGE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     page_q <= RST_VAL;
      else if (wr_en) page_q <= wdata[PAGE_BITS-1:0];
   end

   generate
      if (REG_DW > PAGE_BITS) begin : g_pad
         logic unused_hi;
         assign unused_hi = ^wdata[REG_DW-1:PAGE_BITS];
         assign rdata = {{(REG_DW-PAGE_BITS){1'b0}}, page_q};
      end else begin : g_full
         assign rdata = page_q;
      end
   endgenerate
endmodule

// File: rtl/pwx_region_decode.sv
module pwx_region_decode
   import pwx_pkg::*;
#(
   parameter int QW       = 2,
   parameter int LOW_QUAD = 0,
   parameter int WIN_QUAD = 2
) (
   input  logic [QW-1:0] quad,
   output pwx_region_e   region
);
   always_comb begin
      if (quad == QW'(LOW_QUAD))      region = PWX_RAM;
      else if (quad == QW'(WIN_QUAD)) region = PWX_WIN;
      else                            region = PWX_FIXED;
   end
endmodule

// File: rtl/pwx_addr_map.sv
module pwx_addr_map #(
   parameter int CPU_AW    = 16,
   parameter int OFF_BITS  = 14,
   parameter int PAGE_BITS = 3,
   parameter int WIN_QUAD  = 2,
   parameter int NQ        = 4,
   parameter logic [NQ*PAGE_BITS-1:0] QUAD_PAGE_MAP = '0,
   localparam int PHYS_AW  = OFF_BITS + PAGE_BITS
) (
   input  logic [CPU_AW-1:0]    cpu_addr,
   input  logic [PAGE_BITS-1:0] page_q,
   output logic [PHYS_AW-1:0]   phys_addr
);
   localparam int QW = CPU_AW - OFF_BITS;

   logic [PAGE_BITS-1:0] cand [NQ];
   logic [PAGE_BITS-1:0] sel_page;
   logic [QW-1:0]        quad;

   assign quad = cpu_addr[CPU_AW-1:OFF_BITS];

   genvar q;
   generate
      for (q = 0; q < NQ; q++) begin : g_quad
         if (q == WIN_QUAD) begin : g_win
            assign cand[q] = page_q;
         end else begin : g_fixed
            assign cand[q] = QUAD_PAGE_MAP[q*PAGE_BITS +: PAGE_BITS];
         end
      end
   endgenerate

   assign sel_page  = cand[quad];
   assign phys_addr = {sel_page, cpu_addr[OFF_BITS-1:0]};
endmodule

// File: rtl/page_window_xlate.sv
module page_window_xlate
   import pwx_pkg::*;
#(
   parameter int CPU_AW     = 16,
   parameter int OFF_BITS   = 14,
   parameter int PAGE_BITS  = 3,
   parameter int REG_DW     = 8,
   parameter int RESET_PAGE = 2,
   parameter int LOW_QUAD   = 0,
   parameter int WIN_QUAD   = 2,
   parameter logic [4*PAGE_BITS-1:0] QUAD_PAGE_MAP =
      {PAGE_BITS'(3), PAGE_BITS'(2), PAGE_BITS'(1), PAGE_BITS'(0)},
   localparam int PHYS_AW   = OFF_BITS + PAGE_BITS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_sel,
   input  logic               reg_wr,
   input  logic [REG_DW-1:0]  reg_wdata,
   output logic [REG_DW-1:0]  reg_rdata,
   input  logic [CPU_AW-1:0]  cpu_addr,
   output logic [PHYS_AW-1:0] phys_addr,
   output logic               flash_sel,
   output logic               ram_sel
);
   localparam int QW = CPU_AW - OFF_BITS;
   localparam int NQ = 1 << QW;

   generate
      if (NQ != 4) begin : g_bad_nq
         $error("quadrant map sized for exactly four quarters");
      end
      if (REG_DW < PAGE_BITS) begin : g_bad_dw
         $error("register narrower than page field");
      end
      if (RESET_PAGE >= (1 << PAGE_BITS)) begin : g_bad_rst
         $error("reset page out of range");
      end
      if (WIN_QUAD >= NQ || LOW_QUAD >= NQ || WIN_QUAD == LOW_QUAD) begin : g_bad_quad
         $error("window and low quarter must be distinct and in range");
      end
   endgenerate

   logic [PAGE_BITS-1:0] page_q;
   logic                 wr_en;
   pwx_region_e          region;

   assign wr_en = reg_sel & reg_wr;

   pwx_page_reg #(
      .REG_DW(REG_DW), .PAGE_BITS(PAGE_BITS), .RESET_PAGE(RESET_PAGE)
   ) u_page (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(reg_wdata),
      .page_q(page_q), .rdata(reg_rdata)
   );

   pwx_region_decode #(
      .QW(QW), .LOW_QUAD(LOW_QUAD), .WIN_QUAD(WIN_QUAD)
   ) u_dec (
      .quad(cpu_addr[CPU_AW-1:OFF_BITS]), .region(region)
   );

   pwx_addr_map #(
      .CPU_AW(CPU_AW), .OFF_BITS(OFF_BITS), .PAGE_BITS(PAGE_BITS),
      .WIN_QUAD(WIN_QUAD), .NQ(NQ), .QUAD_PAGE_MAP(QUAD_PAGE_MAP)
   ) u_map (
      .cpu_addr(cpu_addr), .page_q(page_q), .phys_addr(phys_addr)
   );

   assign ram_sel   = (region == PWX_RAM);
   assign flash_sel = (region == PWX_FIXED) || (region == PWX_WIN);
endmodule

// File: rtl/pwx_checker.sv
module pwx_checker #(
   parameter int CPU_AW  = 16,
   parameter int REG_DW  = 8,
   parameter int PHYS_AW = 17
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_sel,
   input logic               reg_wr,
   input logic [REG_DW-1:0]  reg_wdata,
   input logic [REG_DW-1:0]  reg_rdata,
   input logic [CPU_AW-1:0]  cpu_addr,
   input logic [PHYS_AW-1:0] phys_addr,
   input logic               flash_sel,
   input logic               ram_sel
);
   p_one_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({flash_sel, ram_sel}) == 1);

   p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[REG_DW-1:3] == '0);

   p_write_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel && reg_wr) |=> (reg_rdata[2:0] == $past(reg_wdata[2:0])));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_sel && reg_wr) |=> $stable(reg_rdata));

   p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:14] == 2'b10) |->
         (flash_sel && phys_addr[16:14] == reg_rdata[2:0]
          && phys_addr[13:0] == cpu_addr[13:0]));

   p_fixed_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:14] == 2'b01) |-> (flash_sel && phys_addr == {1'b0, cpu_addr}));

   p_fixed_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:14] == 2'b11) |-> (flash_sel && phys_addr == {1'b0, cpu_addr}));

   p_ram_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:14] == 2'b00) |-> (ram_sel && !flash_sel && phys_addr == {1'b0, cpu_addr}));
endmodule

bind page_window_xlate pwx_checker #(
   .CPU_AW(CPU_AW), .REG_DW(REG_DW), .PHYS_AW(PHYS_AW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
   .phys_addr(phys_addr), .flash_sel(flash_sel), .ram_sel(ram_sel)
);

// File: tb/tb_page_window_xlate.sv
module tb_page_window_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic [15:0] cpu_addr = 16'h0000;
   logic [16:0] phys_addr;
   logic        flash_sel;
   logic        ram_sel;

   int tests = 0;
   int fails = 0;
   int ref_page = 2;
   bit done = 1'b0;

   always #2 clk = ~clk;

   page_window_xlate dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
      .phys_addr(phys_addr), .flash_sel(flash_sel), .ram_sel(ram_sel)
   );

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic string tag_for(input int a);
      if (a < 'h4000)      return "R7";
      else if (a < 'h8000) return "R5";
      else if (a < 'hC000) return "R4";
      else                 return "R6";
   endfunction

   function automatic int exp_phys(input int a, input int pg);
      if (a < 'h4000)      return a;
      else if (a < 'h8000) return 'h4000 + (a - 'h4000);
      else if (a < 'hC000) return pg * 'h4000 + (a - 'h8000);
      else                 return 'hC000 + (a - 'hC000);
   endfunction

   // compare outputs against model, then take one clock edge
   task automatic step(input bit sel, input bit wr, input int wd, input int a,
                       input string req);
      string t;
      reg_sel = sel; reg_wr = wr; reg_wdata = wd[7:0]; cpu_addr = a[15:0];
      #1;
      t = (req == "") ? tag_for(a) : req;
      chk({t, " phys"}, int'(phys_addr), exp_phys(a, ref_page));
      chk({"R8 ", t, " flash"}, int'(flash_sel), (a >= 'h4000) ? 1 : 0);
      chk({"R8 ", t, " ram"}, int'(ram_sel), (a < 'h4000) ? 1 : 0);
      chk("R2 rdata", int'(reg_rdata), ref_page);
      @(posedge clk);
      if (sel && wr) ref_page = wd % 8;
      @(negedge clk);
   endtask

   initial begin
      #400000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset rdata", int'(reg_rdata), 2);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rdata after release", int'(reg_rdata), 2);
      // contiguous startup run across pages 1..3
      step(0, 0, 0, 'h7FFF, "R5");
      step(0, 0, 0, 'h8000, "R1");
      step(0, 0, 0, 'hBFFF, "R1");
      step(0, 0, 0, 'hC000, "R6");
      step(0, 0, 0, 'h3FFF, "R7");
      step(0, 0, 0, 'h0000, "R7");
      step(0, 0, 0, 'h4000, "R5");
      step(0, 0, 0, 'hFFFF, "R6");
      // upper bits discarded
      step(1, 1, 'hFD, 'h9000, "R2");
      chk("R2 rdata masked", int'(reg_rdata), 5);
      // write in same cycle as window access: old page used (checked inside step)
      step(1, 1, 'h07, 'h8123, "R3");
      step(0, 0, 0, 'h8123, "R3");
      chk("R3 new page", int'(phys_addr), 'h1C123);
      step(0, 0, 0, 'hBFFF, "R9");
      chk("R9 top", int'(phys_addr), 'h1FFFF);
      step(1, 1, 'h00, 'h4000, "R5");
      step(0, 0, 0, 'h8000, "R9");
      step(0, 0, 0, 'hBFFF, "R9");
      // ignored writes
      step(1, 0, 'h06, 'h8000, "R10");
      step(0, 1, 'h06, 'h8000, "R10");
      chk("R10 rdata", int'(reg_rdata), 0);
      chk("R10 phys", int'(phys_addr), 'h0);
      // random mix
      for (int i = 0; i < 4000; i++) begin
         int a, r, s, w;
         r = $urandom_range(0, 9);
         case (r)
            0: a = 'h3FFF + $urandom_range(0, 1);
            1: a = 'h7FFF + $urandom_range(0, 1);
            2: a = 'hBFFF + $urandom_range(0, 1);
            3: a = 'hFFFF - $urandom_range(0, 1);
            default: a = $urandom_range(0, 'hFFFF);
         endcase
         s = ($urandom_range(0, 3) == 0) ? 1 : 0;
         w = ($urandom_range(0, 2) != 0) ? 1 : 0;
         step(s[0], w[0], $urandom_range(0, 255), a, (s == 1) ? "R3" : "");
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule